// File: doc/BRIEF.md
# Board Control Register File

This block is a small set of board housekeeping registers behind a simple 32-bit read/write strobe bus. Software uses it to light an eight-LED bar, to write eight ASCII characters to a front-panel text buffer, to ask for a soft reset, and to hold a break/reset byte and a general-purpose output byte. It also bit-bangs a two-wire serial bus: one register drives the clock and data line levels, one holds the output enables, one picks whether the general-purpose input mirrors the line register, and one returns the live data line.

The text buffer can be loaded one character at a time, or all at once: a single word write turns the 32-bit value into eight uppercase hex digits. The soft-reset request fires only when one exact magic value is written. The LED state and the text buffer are driven out as parallel ports. The line levels and their enables are also driven out, and the data line is sampled on an input pin.

Only the low 20 address bits are decoded. Offsets with no register read as zero and ignore writes. Read data is registered, and only full-word accesses are supported.

Top module: `board_ctl_regs`

## Requirements
- R1: Only address bits 19:0 are decoded, so 0xFFF00408 reaches the LED register. An offset with no register (for example 0x404 or 0x40C) reads 0, and a write to it changes no register or output.
- R2: The switch register (offset 0x200) and the jumper register (offset 0x210) always read 0. Writes to them are ignored.
- R3: The status register (offset 0x208) reads 0x12 when `big_endian_strap` is 1 and 0x10 when it is 0.
- R4: The LED register (offset 0x408) keeps bits 7:0 of a write, reads them back and drives them on `led_out`. Its reset value is 0x00.
- R5: A write to offset 0x410 sets character k (k = 0..7) to the uppercase ASCII hex digit of write bits [31-4k:28-4k]. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46. Character k appears on `disp_chars[8k+7:8k]`.
- R6: A write to offset 0x418 + 8k (k = 0..7) sets character k to write bits 7:0 and leaves the other characters unchanged. A write at 0x41C, which is off the 8-byte stride, is ignored.
- R7: A write of exactly 0x00000042 to offset 0x500 raises `soft_rst_req` for exactly one cycle, the cycle after the write. Any other value, including 0x142, leaves it low.
- R8: The break register (offset 0x508, reset 0x0A) and the general-purpose output register (offset 0xA00, reset 0x00) each keep bits 7:0 of a write. `gp_out` drives the latter.
- R9: The line-enable register (offset 0xB08) keeps 2 bits and resets to 0. The line-select register (offset 0xB18) keeps 1 bit and resets to 1. The line register (offset 0xB10) keeps the whole word and resets to 3. `scl_level` is its bit 1, `sda_level` is its bit 0, and `line_oe` shows the enable register.
- R10: Offset 0xB00 reads 0b10 with `sda_in` in bit 0. Offset 0xA08 reads the line register when the select bit is 1 and reads 0 when it is 0.
- R11: After reset, all eight characters are ASCII spaces (0x20).
- R12: `bus_rdata` is loaded at the clock edge where `bus_rd` is high, holds its value until the next read, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 32 | Byte address; only bits 19:0 are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| big_endian_strap | input | 1 | Byte-order strap shown in the status register |
| sda_in | input | 1 | Live data line level |
| led_out | output | 8 | LED bar state |
| gp_out | output | 8 | General-purpose output byte |
| disp_chars | output | 64 | Eight ASCII characters, character k at bits 8k+7:8k |
| soft_rst_req | output | 1 | One-cycle soft-reset request |
| scl_level | output | 1 | Clock line output level |
| sda_level | output | 1 | Data line output level |
| line_oe | output | 2 | Line output enables |

## Verification
A decode fault that selects the wrong register, or more than one, shows up on the next read of a neighbouring offset, or as a change on `led_out`, `gp_out` or `disp_chars` in the cycle after a write that should not have touched them. A wrong character latch or hex digit shows on `disp_chars` one cycle after the write. A soft-reset flop that sticks high or fires on the wrong value shows on `soft_rst_req` within two cycles. A fault in the read register shows as read data that changes while no read is active.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int DATA_W     = 32;
  localparam int DEC_W      = 20;
  localparam int NUM_CHARS  = 8;
  localparam int CHAR_W     = 8;
  localparam int SLOT_SHIFT = 3;
  localparam int IDX_W      = $clog2(NUM_CHARS);

  localparam logic [DEC_W-1:0] OFF_SWITCH  = 20'h00200;
  localparam logic [DEC_W-1:0] OFF_STATUS  = 20'h00208;
  localparam logic [DEC_W-1:0] OFF_JUMPER  = 20'h00210;
  localparam logic [DEC_W-1:0] OFF_LED     = 20'h00408;
  localparam logic [DEC_W-1:0] OFF_WORD    = 20'h00410;
  localparam logic [DEC_W-1:0] OFF_SLOT0   = 20'h00418;
  localparam logic [DEC_W-1:0] OFF_SOFTRST = 20'h00500;
  localparam logic [DEC_W-1:0] OFF_BREAK   = 20'h00508;
  localparam logic [DEC_W-1:0] OFF_GPOUT   = 20'h00A00;
  localparam logic [DEC_W-1:0] OFF_GPINP   = 20'h00A08;
  localparam logic [DEC_W-1:0] OFF_LINEIN  = 20'h00B00;
  localparam logic [DEC_W-1:0] OFF_LINEOE  = 20'h00B08;
  localparam logic [DEC_W-1:0] OFF_LINE    = 20'h00B10;
  localparam logic [DEC_W-1:0] OFF_LINESEL = 20'h00B18;

  localparam logic [DATA_W-1:0] SOFTRST_KEY = 32'h0000_0042;
  localparam logic [7:0]        BREAK_RST   = 8'h0A;
  localparam logic [DATA_W-1:0] LINE_RST    = 32'h0000_0003;
  localparam logic [CHAR_W-1:0] CHAR_BLANK  = 8'h20;

  localparam int SEL_SWITCH  = 0;
  localparam int SEL_STATUS  = 1;
  localparam int SEL_JUMPER  = 2;
  localparam int SEL_LED     = 3;
  localparam int SEL_WORD    = 4;
  localparam int SEL_SLOT    = 5;
  localparam int SEL_SOFTRST = 6;
  localparam int SEL_BREAK   = 7;
  localparam int SEL_GPOUT   = 8;
  localparam int SEL_GPINP   = 9;
  localparam int SEL_LINEIN  = 10;
  localparam int SEL_LINEOE  = 11;
  localparam int SEL_LINE    = 12;
  localparam int SEL_LINESEL = 13;
  localparam int SEL_NUM     = 14;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
    if (nib < 4'd10) return 8'h30 + {4'h0, nib};
    else             return 8'h37 + {4'h0, nib};
  endfunction

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
(
  input  logic [DEC_W-1:0]   offset,
  output logic [SEL_NUM-1:0] sel,
  output logic [IDX_W-1:0]   slot_idx
);
  localparam logic [DEC_W-1:0] SLOT_SPAN = DEC_W'((NUM_CHARS - 1) << SLOT_SHIFT);

  logic [DEC_W-1:0] rel;
  logic             slot_hit;

  always_comb begin
    rel      = offset - OFF_SLOT0;
    slot_hit = (offset >= OFF_SLOT0) && (rel <= SLOT_SPAN) &&
               (rel[SLOT_SHIFT-1:0] == '0);
    slot_idx = rel[SLOT_SHIFT +: IDX_W];
  end

  always_comb begin
    sel = '0;
    case (offset)
      OFF_SWITCH:  sel[SEL_SWITCH]  = 1'b1;
      OFF_STATUS:  sel[SEL_STATUS]  = 1'b1;
      OFF_JUMPER:  sel[SEL_JUMPER]  = 1'b1;
      OFF_LED:     sel[SEL_LED]     = 1'b1;
      OFF_WORD:    sel[SEL_WORD]    = 1'b1;
      OFF_SOFTRST: sel[SEL_SOFTRST] = 1'b1;
      OFF_BREAK:   sel[SEL_BREAK]   = 1'b1;
      OFF_GPOUT:   sel[SEL_GPOUT]   = 1'b1;
      OFF_GPINP:   sel[SEL_GPINP]   = 1'b1;
      OFF_LINEIN:  sel[SEL_LINEIN]  = 1'b1;
      OFF_LINEOE:  sel[SEL_LINEOE]  = 1'b1;
      OFF_LINE:    sel[SEL_LINE]    = 1'b1;
      OFF_LINESEL: sel[SEL_LINESEL] = 1'b1;
      default:     sel[SEL_SLOT]    = slot_hit;
    endcase
  end

  // R1: an offset selects at most one register
  always_comb begin
    a_onehot_sel_r1: assert ($onehot0(sel));
  end

endmodule

// File: rtl/board_ctl_charbuf.sv
module board_ctl_charbuf
  import board_ctl_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        word_we,
  input  logic                        slot_we,
  input  logic [IDX_W-1:0]            slot_idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_CHARS*CHAR_W-1:0] chars
);

  generate
    for (genvar k = 0; k < NUM_CHARS; k++) begin : g_char
      localparam int NIB_LO = 4 * (NUM_CHARS - 1 - k);
      logic [CHAR_W-1:0] cur_q, nxt;
      logic              en;

      always_comb begin
        en  = word_we || (slot_we && (slot_idx == IDX_W'(k)));
        nxt = word_we ? nib_to_ascii(wdata[NIB_LO +: 4]) : wdata[CHAR_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cur_q <= CHAR_BLANK;
        else if (en) cur_q <= nxt;
      end

      assign chars[k*CHAR_W +: CHAR_W] = cur_q;
    end
  endgenerate

  // R5: after a word write, character 0 is always a hex digit
  p_word_hex_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_we) |-> ((chars[7:0] >= 8'h30 && chars[7:0] <= 8'h39) ||
                        (chars[7:0] >= 8'h41 && chars[7:0] <= 8'h46)));

  // R6: the last character changes only through a word write or its own slot write
  p_slot_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_we && !(slot_we && slot_idx == IDX_W'(NUM_CHARS - 1)))
      |=> $stable(chars[NUM_CHARS*CHAR_W-1 -: CHAR_W]));

endmodule

// File: rtl/board_ctl_line.sv
module board_ctl_line
  import board_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_we,
  input  logic              line_we,
  input  logic              sel_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sda_in,
  output logic [1:0]        oe,
  output logic [DATA_W-1:0] line,
  output logic              line_sel,
  output logic [DATA_W-1:0] in_word,
  output logic [DATA_W-1:0] gpinp_word
);
  logic [1:0]        oe_q, oe_d;
  logic [DATA_W-1:0] line_q, line_d;
  logic              sel_q, sel_d;

  always_comb begin
    oe_d   = oe_we   ? wdata[1:0] : oe_q;
    line_d = line_we ? wdata      : line_q;
    sel_d  = sel_we  ? wdata[0]   : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      line_q <= LINE_RST;
      sel_q  <= 1'b1;
    end else begin
      oe_q   <= oe_d;
      line_q <= line_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    oe         = oe_q;
    line       = line_q;
    line_sel   = sel_q;
    in_word    = {{(DATA_W-2){1'b0}}, 1'b1, sda_in};
    gpinp_word = sel_q ? line_q : '0;
  end

  // R9: the line register changes only on its own write
  p_line_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_we |=> $stable(line));

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [31:0]                 bus_addr,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic                        big_endian_strap,
  input  logic                        sda_in,
  output logic [7:0]                  led_out,
  output logic [7:0]                  gp_out,
  output logic [NUM_CHARS*CHAR_W-1:0] disp_chars,
  output logic                        soft_rst_req,
  output logic                        scl_level,
  output logic                        sda_level,
  output logic [1:0]                  line_oe
);
  // reset synchronizer: asserted at once, released on a clock edge
  logic rst_meta_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  logic unused_addr_hi;
  assign unused_addr_hi = ^bus_addr[31:DEC_W];

  logic [SEL_NUM-1:0] sel;
  logic [IDX_W-1:0]   slot_idx;

  board_ctl_decode u_dec (
    .offset   (bus_addr[DEC_W-1:0]),
    .sel      (sel),
    .slot_idx (slot_idx)
  );

  logic [SEL_NUM-1:0] we;
  assign we = sel & {SEL_NUM{bus_wr}};

  board_ctl_charbuf u_chars (
    .clk      (clk),
    .rst_n    (rst_s),
    .word_we  (we[SEL_WORD]),
    .slot_we  (we[SEL_SLOT]),
    .slot_idx (slot_idx),
    .wdata    (bus_wdata),
    .chars    (disp_chars)
  );

  logic [DATA_W-1:0] line_word, in_word, gpinp_word;
  logic              line_sel;
  logic [1:0]        oe_q;

  board_ctl_line u_line (
    .clk        (clk),
    .rst_n      (rst_s),
    .oe_we      (we[SEL_LINEOE]),
    .line_we    (we[SEL_LINE]),
    .sel_we     (we[SEL_LINESEL]),
    .wdata      (bus_wdata),
    .sda_in     (sda_in),
    .oe         (oe_q),
    .line       (line_word),
    .line_sel   (line_sel),
    .in_word    (in_word),
    .gpinp_word (gpinp_word)
  );

  // byte registers and soft-reset pulse
  logic [7:0]  led_q, led_d, brk_q, brk_d, gp_q, gp_d;
  logic        srst_q, srst_d;
  logic [31:0] rdata_q, rdata_d;

  always_comb begin
    led_d  = we[SEL_LED]   ? bus_wdata[7:0] : led_q;
    brk_d  = we[SEL_BREAK] ? bus_wdata[7:0] : brk_q;
    gp_d   = we[SEL_GPOUT] ? bus_wdata[7:0] : gp_q;
    srst_d = we[SEL_SOFTRST] && (bus_wdata == SOFTRST_KEY);
  end

  // read mux; switch, jumper, word, slots and soft reset read zero
  always_comb begin
    rdata_d = '0;
    if (sel[SEL_STATUS])  rdata_d = {27'd0, 1'b1, 2'b00, big_endian_strap, 1'b0};
    if (sel[SEL_LED])     rdata_d = {24'd0, led_q};
    if (sel[SEL_BREAK])   rdata_d = {24'd0, brk_q};
    if (sel[SEL_GPOUT])   rdata_d = {24'd0, gp_q};
    if (sel[SEL_GPINP])   rdata_d = gpinp_word;
    if (sel[SEL_LINEIN])  rdata_d = in_word;
    if (sel[SEL_LINEOE])  rdata_d = {30'd0, oe_q};
    if (sel[SEL_LINE])    rdata_d = line_word;
    if (sel[SEL_LINESEL]) rdata_d = {31'd0, line_sel};
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      led_q   <= '0;
      brk_q   <= BREAK_RST;
      gp_q    <= '0;
      srst_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      led_q  <= led_d;
      brk_q  <= brk_d;
      gp_q   <= gp_d;
      srst_q <= srst_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign led_out      = led_q;
  assign gp_out       = gp_q;
  assign soft_rst_req = srst_q;
  assign scl_level    = line_word[1];
  assign sda_level    = line_word[0];
  assign line_oe      = oe_q;

  // R7: the request is a single-cycle pulse
  p_srst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_s)
    soft_rst_req |=> !soft_rst_req);

  // R7: the request only follows a key write to the soft-reset offset
  p_srst_cause_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(soft_rst_req) |-> $past(bus_wr && bus_addr[DEC_W-1:0] == OFF_SOFTRST &&
                                  bus_wdata == SOFTRST_KEY));

  // R12: read data holds while no read is active
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_rd |=> $stable(bus_rdata));

  // R4: the LED output changes only on an LED write
  p_led_keep_r4: assert property (@(posedge clk) disable iff (!rst_s)
    !(bus_wr && bus_addr[DEC_W-1:0] == OFF_LED) |=> $stable(led_out));

endmodule

// File: tb/sim_board_ctl_regs.sv
module sim_board_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd, big_endian_strap, sda_in;
  logic [7:0]  led_out, gp_out;
  logic [63:0] disp_chars;
  logic        soft_rst_req, scl_level, sda_level;
  logic [1:0]  line_oe;

  always #2.5 clk = ~clk;

  board_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .big_endian_strap(big_endian_strap), .sda_in(sda_in),
    .led_out(led_out), .gp_out(gp_out), .disp_chars(disp_chars),
    .soft_rst_req(soft_rst_req), .scl_level(scl_level),
    .sda_level(sda_level), .line_oe(line_oe)
  );

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { string tag; logic [31:0] addr; logic [31:0] exp; } exp_t;
  exp_t sb_q[$];
  logic rd_seen = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R12: unexpected read data %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check($sformatf("%s read %h", e.tag, e.addr), {32'd0, bus_rdata}, {32'd0, e.exp});
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [31:0] a, input logic [31:0] exp);
    exp_t e;
    e.tag = tag; e.addr = a; e.exp = exp;
    sb_q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [63:0] hex_text(input logic [31:0] w);
    string digits = "0123456789ABCDEF";
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = digits[w[31-4*k -: 4]];
    return r;
  endfunction

  logic [63:0] txt;

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none

    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    big_endian_strap = 1'b0; sda_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R12 rdata reset", {32'd0, bus_rdata}, 64'd0);
    check("R11 blank text", disp_chars, {8{8'h20}});
    check("R4 led reset", {56'd0, led_out}, 64'd0);
    check("R9 line levels reset", {62'd0, scl_level, sda_level}, 64'd3);
    check("R9 oe reset", {62'd0, line_oe}, 64'd0);
    rd("R2", 32'h200, 0);
    rd("R2", 32'h210, 0);
    rd("R4", 32'h408, 0);
    rd("R8", 32'h508, 32'h0A);
    rd("R8", 32'hA00, 0);
    rd("R9", 32'hB08, 0);
    rd("R9", 32'hB10, 3);
    rd("R9", 32'hB18, 1);
    rd("R10", 32'hA08, 3);
    rd("R10", 32'hB00, 3);

    // status strap
    rd("R3", 32'h208, 32'h10);
    big_endian_strap = 1'b1;
    rd("R3", 32'h208, 32'h12);

    // LED and alias decode
    wr(32'h0ABC_D1E5, 32'h0);
    wr(32'h408, 32'hABCD_01E5);
    check("R4 led_out", {56'd0, led_out}, 64'hE5);
    rd("R4", 32'h408, 32'hE5);
    wr(32'hFFF0_0408, 32'h3C);
    check("R1 alias led_out", {56'd0, led_out}, 64'h3C);
    wr(32'h404, 32'hFF);
    wr(32'h40C, 32'hFF);
    check("R1 unmapped write", {56'd0, led_out}, 64'h3C);
    rd("R1", 32'h404, 0);
    rd("R1", 32'h40C, 0);
    rd("R1", 32'hFFF0_0408, 32'h3C);
    wr(32'h200, 32'hFFFF_FFFF);
    wr(32'h210, 32'hFFFF_FFFF);
    rd("R2", 32'h200, 0);
    rd("R2", 32'h210, 0);

    // hex word fill
    wr(32'h410, 32'h1A2B_3C4F);
    check("R5 hex 1A2B3C4F", disp_chars, hex_text(32'h1A2B_3C4F));
    wr(32'h410, 32'h00FE_DCB9);
    check("R5 hex 00FEDCB9", disp_chars, hex_text(32'h00FE_DCB9));

    // slot writes
    txt = hex_text(32'h00FE_DCB9);
    wr(32'h430, 32'h1234_5678);
    txt[8*3 +: 8] = 8'h78;
    check("R6 slot3", disp_chars, txt);
    wr(32'h418, 32'h41);
    txt[7:0] = 8'h41;
    check("R6 slot0", disp_chars, txt);
    wr(32'h450, 32'h7A);
    txt[63:56] = 8'h7A;
    check("R6 slot7", disp_chars, txt);
    wr(32'h41C, 32'h55);
    check("R6 off-stride ignored", disp_chars, txt);

    // soft reset key
    wr(32'h500, 32'h43);
    check("R7 wrong key", {63'd0, soft_rst_req}, 0);
    wr(32'h500, 32'h142);
    check("R7 wide key", {63'd0, soft_rst_req}, 0);
    wr(32'h500, 32'h42);
    check("R7 pulse high", {63'd0, soft_rst_req}, 1);
    @(negedge clk);
    check("R7 pulse one cycle", {63'd0, soft_rst_req}, 0);

    // byte registers
    wr(32'h508, 32'h1FF);
    wr(32'hA00, 32'h155);
    check("R8 gp_out", {56'd0, gp_out}, 64'h55);
    rd("R8", 32'h508, 32'hFF);
    rd("R8", 32'hA00, 32'h55);

    // line registers
    wr(32'hB08, 32'hF);
    check("R9 line_oe", {62'd0, line_oe}, 64'd3);
    rd("R9", 32'hB08, 3);
    wr(32'hB10, 32'hDEAD_BEE2);
    check("R9 levels", {62'd0, scl_level, sda_level}, 64'd2);
    rd("R9", 32'hB10, 32'hDEAD_BEE2);
    rd("R10", 32'hA08, 32'hDEAD_BEE2);
    wr(32'hB18, 32'h2);
    rd("R9", 32'hB18, 0);
    rd("R10", 32'hA08, 0);
    wr(32'hB18, 32'h3);
    rd("R10", 32'hA08, 32'hDEAD_BEE2);
    sda_in = 1'b0;
    rd("R10", 32'hB00, 2);

    // read data holds between reads
    repeat (3) @(negedge clk);
    check("R12 hold", {32'd0, bus_rdata}, 64'd2);

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R12: actual %0d pending reads expected 0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule